// File: doc/BRIEF.md
# Transceiver Interrupt Status and Enable Logic

This block keeps the interrupt flags of a low-rate radio transceiver and drives the single interrupt line toward the host. Two one-cycle event pulses feed it: one when a frame queued for ordinary transmission has been sent, one when a frame has been received. Each pulse sets its own flag in a status register. The flag then stays set until software reads that register. The read clears every flag at once.

A control register holds one disable bit for each source. A 1 in a disable bit keeps that source off the line. A separate configuration register selects whether the line is active high or active low. The line is level style. It stays asserted as long as any enabled flag is set, so an event that lands between two host reads is not lost. A register-access front end, outside this block, decodes the serial commands. It passes this block read and write strobes with an address and a data byte. Short registers sit at addresses below 0x040, and long registers sit at 0x200 and above.

Top module: `radio_irq_ctrl`

## Requirements
- R1: After reset all status flags are 0, the control register reads 0xFF (every source disabled), the pin configuration register reads 0x00, and the pin sits at its inactive level, which is high.
- R2: A transmit-done pulse sets status bit 0 and a frame-received pulse sets status bit 3. The status register is read at address 0x031, and its other bits read 0.
- R3: A read of address 0x031 clears all status flags. The read data is the value the register held before that clear, and a second read returns 0x00.
- R4: When an event pulse arrives in the same cycle as a read of 0x031, the read returns the old value and the event's flag stays set afterwards.
- R5: Control register 0x032 holds the disable bits: bit 0 for transmit-done and bit 3 for frame-received, where 1 disables. A disabled flag still latches its event but does not assert the pin.
- R6: The pin is asserted for as long as at least one enabled flag is set, and it returns to inactive in the cycle after a clearing read.
- R7: Bit 1 of long register 0x211 selects the polarity: 1 makes the pin active high and 0 makes it active low. The register reads back what was written.
- R8: The read data and a read-valid strobe appear one cycle after the read strobe. The strobe is high only for that one cycle.
- R9: A write to 0x031 changes nothing. A read of an unmapped address returns 0x00. The control register is a full byte that reads back exactly what was written.
- R10: A repeated event on a flag that is already set leaves that flag set and the pin asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_tx_done | input | 1 | One-cycle pulse: ordinary transmission finished |
| ev_rx_frame | input | 1 | One-cycle pulse: frame received |
| reg_addr | input | 10 | Register address from the access front end |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read data |
| rd_valid | output | 1 | High for one cycle when rd_data is new |
| irq_pin | output | 1 | Interrupt line, polarity set by configuration |

## Verification
The hardest case to reach is an event pulse landing in exactly the cycle that a clearing status read is accepted. If this is handled wrongly, an interrupt is lost. The stimulus table places an event strobe and a read strobe in one row. It then checks that the returned byte lacks the new flag, that the pin stays asserted, and that the next read returns the flag. Flags latched while their source was disabled are also checked: they are read back after the source is enabled.

// File: rtl/radio_irq_pkg.sv
`timescale 1ns/1ps
package radio_irq_pkg;

  // Event sources modelled by this block
  localparam int NUM_SRC = 2;
  localparam int SRC_TX  = 0;
  localparam int SRC_RX  = 1;

  // Register addresses (short space below 0x040, long space from 0x200)
  localparam int ADR_STATUS = 'h031;
  localparam int ADR_MASK   = 'h032;
  localparam int ADR_PINCFG = 'h211;

  // Bit of the pin configuration register that selects active-high
  localparam int PINCFG_POL_BIT = 1;

  // Status/mask bit position for each source
  function automatic int src_bit(input int idx);
    return (idx == SRC_RX) ? 3 : 0;
  endfunction

  // Pin level for a pending state and a polarity choice
  function automatic logic drive_level(input logic pending, input logic act_high);
    return act_high ? pending : ~pending;
  endfunction

endpackage

// File: rtl/radio_irq_flag.sv
`timescale 1ns/1ps
module radio_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_pulse,
  input  logic clr_req,
  output logic flag_q
);

  logic flag_d;

  // An event always wins over a clearing read in the same cycle
  assign flag_d = set_pulse | (flag_q & ~clr_req);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    set_pulse |=> flag_q);

  a_r3_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !set_pulse) |=> !flag_q);

  a_r10_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_pulse && !clr_req) |=> $stable(flag_q));

endmodule

// File: rtl/radio_irq_cfg.sv
`timescale 1ns/1ps
module radio_irq_cfg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_mask,
  input  logic              wr_pincfg,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] mask_q,
  output logic [DATA_W-1:0] pincfg_q
);

  localparam logic [DATA_W-1:0] MASK_RST   = '1;
  localparam logic [DATA_W-1:0] PINCFG_RST = '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= MASK_RST;
    else if (wr_mask) mask_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pincfg_q <= PINCFG_RST;
    else if (wr_pincfg) pincfg_q <= wdata;
  end

  a_r5_mask_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_mask |=> $stable(mask_q));

  a_r7_pincfg_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_pincfg |=> $stable(pincfg_q));

  a_r9_mask_takes_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask |=> (mask_q == $past(wdata)));

endmodule

// File: rtl/radio_irq_rdmux.sv
`timescale 1ns/1ps
module radio_irq_rdmux #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              hit_status,
  input  logic              hit_mask,
  input  logic              hit_pincfg,
  input  logic [DATA_W-1:0] status_byte,
  input  logic [DATA_W-1:0] mask_byte,
  input  logic [DATA_W-1:0] pincfg_byte,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);

  logic [DATA_W-1:0] sel_byte;

  always_comb begin
    sel_byte = '0;
    if (hit_status)      sel_byte = status_byte;
    else if (hit_mask)   sel_byte = mask_byte;
    else if (hit_pincfg) sel_byte = pincfg_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= sel_byte;
    end
  end

  a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  a_r8_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);

  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !hit_status && !hit_mask && !hit_pincfg) |=> (rd_data == '0));

endmodule

// File: rtl/radio_irq_ctrl.sv
`timescale 1ns/1ps
module radio_irq_ctrl #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_tx_done,
  input  logic              ev_rx_frame,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_wr,
  input  logic              reg_rd,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              irq_pin
);
  import radio_irq_pkg::*;

  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(ADR_STATUS);
  localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(ADR_MASK);
  localparam logic [ADDR_W-1:0] A_PINCFG = ADDR_W'(ADR_PINCFG);

  // Address decode
  logic hit_status, hit_mask, hit_pincfg;
  assign hit_status = (reg_addr == A_STATUS);
  assign hit_mask   = (reg_addr == A_MASK);
  assign hit_pincfg = (reg_addr == A_PINCFG);

  // Named internal events
  logic status_rd_clr;
  logic wr_mask, wr_pincfg;
  assign status_rd_clr = reg_rd & hit_status;
  assign wr_mask       = reg_wr & hit_mask;
  assign wr_pincfg     = reg_wr & hit_pincfg;

  logic [NUM_SRC-1:0] ev_vec;
  assign ev_vec[SRC_TX] = ev_tx_done;
  assign ev_vec[SRC_RX] = ev_rx_frame;

  // Status flags, one per source
  logic [NUM_SRC-1:0] flag_q;
  for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_flag
    radio_irq_flag flag_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_pulse (ev_vec[gi]),
      .clr_req   (status_rd_clr),
      .flag_q    (flag_q[gi])
    );
  end

  // Control and pin configuration registers
  logic [DATA_W-1:0] mask_q, pincfg_q;
  radio_irq_cfg #(.DATA_W(DATA_W)) cfg_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_mask    (wr_mask),
    .wr_pincfg  (wr_pincfg),
    .wdata      (reg_wdata),
    .mask_q     (mask_q),
    .pincfg_q   (pincfg_q)
  );

  // Status byte image and per-source disable bits
  logic [DATA_W-1:0]  status_byte;
  logic [NUM_SRC-1:0] src_dis;
  always_comb begin
    status_byte = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      status_byte[src_bit(i)] = flag_q[i];
      src_dis[i]              = mask_q[src_bit(i)];
    end
  end

  // Pin drive
  logic pending, act_high;
  assign pending  = |(flag_q & ~src_dis);
  assign act_high = pincfg_q[PINCFG_POL_BIT];
  assign irq_pin  = drive_level(pending, act_high);

  // Read path
  radio_irq_rdmux #(.DATA_W(DATA_W)) rdmux_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_en       (reg_rd),
    .hit_status  (hit_status),
    .hit_mask    (hit_mask),
    .hit_pincfg  (hit_pincfg),
    .status_byte (status_byte),
    .mask_byte   (mask_q),
    .pincfg_byte (pincfg_q),
    .rd_data     (rd_data),
    .rd_valid    (rd_valid)
  );

  a_r5_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (&src_dis) |-> (irq_pin == ~act_high));

  a_r6_enabled_asserts: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_q & ~src_dis) != '0) |-> (irq_pin == act_high));

  a_r3_read_returns_old: assert property (@(posedge clk) disable iff (!rst_n)
    status_rd_clr |=> (rd_data == $past(status_byte)));

  a_r4_event_survives_read: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd_clr && ev_tx_done) |=> flag_q[SRC_TX]);

endmodule

// File: tb/radio_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module radio_irq_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ev_tx_done = 1'b0, ev_rx_frame = 1'b0;
  logic [9:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] rd_data;
  logic       rd_valid, irq_pin;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  radio_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .ev_tx_done(ev_tx_done), .ev_rx_frame(ev_rx_frame),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .rd_data(rd_data), .rd_valid(rd_valid), .irq_pin(irq_pin)
  );

  typedef struct packed {
    logic [3:0] req;
    logic       tx, rx, wr, rd;
    logic [9:0] addr;
    logic [7:0] wdata;
    logic       pin, rdv;
    logic [7:0] rdat;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t TBL [NV] = '{
    '{4'd1, 1'b0,1'b0,1'b0,1'b1, 10'h032, 8'h00, 1'b1,1'b1, 8'hFF}, // R1 control reset
    '{4'd1, 1'b0,1'b0,1'b0,1'b1, 10'h211, 8'h00, 1'b1,1'b1, 8'h00}, // R1 pin config reset
    '{4'd1, 1'b0,1'b0,1'b0,1'b1, 10'h031, 8'h00, 1'b1,1'b1, 8'h00}, // R1 status reset
    '{4'd5, 1'b1,1'b0,1'b0,1'b0, 10'h000, 8'h00, 1'b1,1'b0, 8'h00}, // R5 masked tx latches
    '{4'd5, 1'b0,1'b0,1'b0,1'b1, 10'h031, 8'h00, 1'b1,1'b1, 8'h01}, // R5 latched flag seen
    '{4'd5, 1'b0,1'b0,1'b1,1'b0, 10'h032, 8'h00, 1'b1,1'b0, 8'h00}, // R5 enable both
    '{4'd9, 1'b0,1'b0,1'b0,1'b1, 10'h032, 8'h00, 1'b1,1'b1, 8'h00}, // R9 control readback
    '{4'd2, 1'b0,1'b1,1'b0,1'b0, 10'h000, 8'h00, 1'b0,1'b0, 8'h00}, // R2 rx sets, pin low
    '{4'd6, 1'b0,1'b0,1'b0,1'b0, 10'h000, 8'h00, 1'b0,1'b0, 8'h00}, // R6 level held
    '{4'd10,1'b0,1'b1,1'b0,1'b0, 10'h000, 8'h00, 1'b0,1'b0, 8'h00}, // R10 repeat event
    '{4'd3, 1'b0,1'b0,1'b0,1'b1, 10'h031, 8'h00, 1'b1,1'b1, 8'h08}, // R3 read old, clear
    '{4'd3, 1'b0,1'b0,1'b0,1'b1, 10'h031, 8'h00, 1'b1,1'b1, 8'h00}, // R3 second read 0
    '{4'd4, 1'b1,1'b0,1'b0,1'b1, 10'h031, 8'h00, 1'b0,1'b1, 8'h00}, // R4 event vs read
    '{4'd4, 1'b0,1'b0,1'b0,1'b1, 10'h031, 8'h00, 1'b1,1'b1, 8'h01}, // R4 event survived
    '{4'd9, 1'b0,1'b0,1'b1,1'b0, 10'h031, 8'hFF, 1'b1,1'b0, 8'h00}, // R9 write status
    '{4'd9, 1'b0,1'b0,1'b0,1'b1, 10'h031, 8'h00, 1'b1,1'b1, 8'h00}, // R9 status unchanged
    '{4'd9, 1'b0,1'b0,1'b1,1'b0, 10'h032, 8'hFF, 1'b1,1'b0, 8'h00}, // R9 disable all
    '{4'd9, 1'b0,1'b0,1'b0,1'b1, 10'h032, 8'h00, 1'b1,1'b1, 8'hFF}, // R9 readback
    '{4'd7, 1'b0,1'b0,1'b1,1'b0, 10'h211, 8'h02, 1'b0,1'b0, 8'h00}, // R7 active high idle
    '{4'd7, 1'b0,1'b0,1'b0,1'b1, 10'h211, 8'h00, 1'b0,1'b1, 8'h02}, // R7 readback
    '{4'd5, 1'b1,1'b0,1'b0,1'b0, 10'h000, 8'h00, 1'b0,1'b0, 8'h00}, // R5 masked, quiet
    '{4'd5, 1'b0,1'b0,1'b1,1'b0, 10'h032, 8'h08, 1'b1,1'b0, 8'h00}, // R5 enable tx only
    '{4'd9, 1'b0,1'b0,1'b0,1'b1, 10'h100, 8'h00, 1'b1,1'b1, 8'h00}, // R9 unmapped read
    '{4'd3, 1'b0,1'b0,1'b0,1'b1, 10'h031, 8'h01, 1'b0,1'b1, 8'h01}, // R3 clear, R6 release
    '{4'd8, 1'b0,1'b0,1'b0,1'b0, 10'h000, 8'h00, 1'b0,1'b0, 8'h00}  // R8 strobe single
  };

  task automatic chk(input int req, input int act, input int exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic access(input logic tx, rx, wr, rd, input logic [9:0] a, input logic [7:0] d);
    @(negedge clk);
    ev_tx_done = tx; ev_rx_frame = rx; reg_wr = wr; reg_rd = rd;
    reg_addr = a; reg_wdata = d;
    @(posedge clk);
    #1;
    ev_tx_done = 1'b0; ev_rx_frame = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0;
  endtask

  initial begin
    #5000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(1, irq_pin, 1, "pin during reset");               // R1
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      access(TBL[i].tx, TBL[i].rx, TBL[i].wr, TBL[i].rd, TBL[i].addr, TBL[i].wdata);
      chk(TBL[i].req, irq_pin, TBL[i].pin, $sformatf("pin row %0d", i));
      chk(TBL[i].req, rd_valid, TBL[i].rdv, $sformatf("valid row %0d", i));
      if (TBL[i].rdv) chk(TBL[i].req, rd_data, TBL[i].rdat, $sformatf("data row %0d", i));
    end
    // R6: active-high pin with tx enabled asserts high
    access(1'b1, 1'b0, 1'b0, 1'b0, 10'h000, 8'h00);
    chk(6, irq_pin, 1, "active-high assert");
    // R1: reset mid-run restores defaults
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk(1, irq_pin, 1, "pin after reset");
    rst_n = 1'b1;
    access(1'b0, 1'b0, 1'b0, 1'b1, 10'h031, 8'h00);
    chk(1, rd_data, 8'h00, "status after reset");
    access(1'b0, 1'b0, 1'b0, 1'b1, 10'h211, 8'h00);
    chk(1, rd_data, 8'h00, "pin config after reset");
    access(1'b0, 1'b0, 1'b0, 1'b1, 10'h032, 8'h00);
    chk(1, rd_data, 8'hFF, "control after reset");
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule